// File: doc/BRIEF.md
# Packet Head-Tail Splitter with In-Order Release

This block sits at the ingress of a packet engine and receives packets one byte per cycle from a network or fabric port. Short packets are passed whole to a lookup engine. For long packets only a fixed-size leading part (the head) goes to lookup, and the remaining bytes stream out on a tail port towards an external buffer. When a packet's first byte arrives, the block allocates a reorder identifier for it. It also marks the packet high priority when that first byte equals a programmable control-class value.

The lookup engine may hand processed heads back in any order by returning their identifiers. The block holds a tracker of outstanding packets. It releases one record per cycle to a scheduler, always in arrival order. A packet is released only once it has been returned and all of its bytes have left on the lookup and tail ports. The release record tells the scheduler whether a tail must be fetched.

A return that names an identifier with no outstanding completion is flagged and has no other effect. When every identifier is in use, the input stalls at the next packet boundary.

Top module: `head_tail_splitter`

## Requirements
- R1: A packet of 224 bytes or fewer leaves whole on the lookup port in input order, with `lk_last` set on its final byte, and produces no tail beat.
- R2: For a packet longer than 224 bytes, exactly its first 192 bytes leave on the lookup port, with `lk_last` set on byte 192.
- R3: For a packet longer than 224 bytes, bytes 193 through the end leave on the tail port in order, with `tl_last` on the final byte. A lookup beat and a tail beat are never valid in the same cycle.
- R4: Identifiers are assigned when the first byte is accepted, in ascending order modulo 16 starting at 0 after reset. Every lookup and tail beat of a packet carries that packet's identifier.
- R5: Release records leave in arrival order, at most one per cycle. Each record goes out only after its identifier has been returned and its last byte has been issued. The record carries the identifier, the total length in bytes, a tail flag equal to 1 exactly when the length exceeds 224, and the priority bit.
- R6: The priority bit is 1 when the packet's first byte equals `ctrl_class`, and 0 otherwise.
- R7: At most 16 packets are outstanding. With 16 outstanding, `in_ready` stays low at a packet boundary until one is released.
- R8: A return naming an identifier that is free, or that was already returned, raises `ret_err` for one cycle, in the cycle after the return. It changes no state: no extra release results.
- R9: After reset, `in_ready` is 1 and `lk_valid`, `tl_valid`, `rel_valid` and `ret_err` are 0.
- R10: Returns may arrive in any order. A younger returned packet waits until every older packet has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the packet |
| ctrl_class | input | 8 | First-byte value that marks high priority |
| lk_valid | output | 1 | Lookup beat valid |
| lk_data | output | 8 | Lookup byte |
| lk_last | output | 1 | Last byte of head or whole packet |
| lk_tag | output | 4 | Reorder identifier of the lookup beat |
| tl_valid | output | 1 | Tail beat valid |
| tl_data | output | 8 | Tail byte |
| tl_last | output | 1 | Last byte of the tail |
| tl_tag | output | 4 | Reorder identifier of the tail beat |
| ret_valid | input | 1 | Lookup completion valid |
| ret_tag | input | 4 | Identifier being completed |
| ret_err | output | 1 | Completion named a non-outstanding identifier |
| rel_valid | output | 1 | Release record valid |
| rel_tag | output | 4 | Released identifier |
| rel_len | output | 14 | Packet length in bytes |
| rel_tail | output | 1 | Packet has a tail in the buffer |
| rel_hi | output | 1 | High priority |

## Verification
Each of the first 191 bytes of a packet appears on the lookup port one cycle after it is accepted. Bytes from position 192 onward wait in the hold queue: a short packet drains them to lookup once its last byte is in, and a long packet starts to drain them when byte 225 arrives. The bench therefore compares lookup and tail beats against per-port expected queues on every falling edge, whatever the stall pattern. `ret_err` is due exactly one cycle after a return, and a release two cycles after the return that makes the oldest packet eligible. The bench samples both at those exact falling edges, with a small delay after the edge so that the monitor's counters have settled.

// File: rtl/head_tail_splitter.sv
module head_tail_splitter #(
  parameter int DATA_W    = 8,
  parameter int WHOLE_MAX = 224,
  parameter int HEAD_LEN  = 192,
  parameter int DEPTH     = 16,
  parameter int LEN_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [DATA_W-1:0] ctrl_class,
  output logic              lk_valid,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_last,
  output logic [$clog2(DEPTH)-1:0] lk_tag,
  output logic              tl_valid,
  output logic [DATA_W-1:0] tl_data,
  output logic              tl_last,
  output logic [$clog2(DEPTH)-1:0] tl_tag,
  input  logic              ret_valid,
  input  logic [$clog2(DEPTH)-1:0] ret_tag,
  output logic              ret_err,
  output logic              rel_valid,
  output logic [$clog2(DEPTH)-1:0] rel_tag,
  output logic [LEN_W-1:0]  rel_len,
  output logic              rel_tail,
  output logic              rel_hi
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int OC_W  = TAG_W + 1;
  localparam int HOLD  = WHOLE_MAX - HEAD_LEN + 2;
  localparam int FP_W  = $clog2(HOLD);
  localparam int FC_W  = $clog2(HOLD + 1);

  logic             in_pkt, lkd, tlm, hd_pend;
  logic [LEN_W-1:0] pos;
  logic [TAG_W-1:0] cur_tag, wp, rp;
  logic [OC_W-1:0]  occ;
  logic [DEPTH-1:0] alloc, done, closed, tailf, hif;
  logic [LEN_W-1:0] lenm [DEPTH];

  logic [DATA_W:0]  fmem [HOLD];
  logic [FP_W-1:0]  fwp, frp;
  logic [FC_W-1:0]  fcnt;

  logic             accept, start, direct, push, pop, room, elig, ret_ok;
  logic [TAG_W-1:0] tag_now;
  logic [DATA_W:0]  f_out;

  assign accept  = in_valid && in_ready;
  assign start   = accept && !in_pkt;
  assign tag_now = in_pkt ? cur_tag : wp;
  assign direct  = accept && (pos < LEN_W'(HEAD_LEN - 1));
  assign push    = accept && (pos >= LEN_W'(HEAD_LEN - 1));
  assign pop     = (lkd || tlm) && (fcnt != '0);
  assign f_out   = fmem[frp];
  assign room    = (fcnt < FC_W'(HOLD)) || (tlm && fcnt != '0);
  assign in_ready = !lkd && !(tlm && !in_pkt) && (in_pkt || occ < OC_W'(DEPTH)) && room;
  assign elig    = alloc[rp] && done[rp] && closed[rp];
  assign ret_ok  = ret_valid && alloc[ret_tag] && !done[ret_tag];

  always_ff @(posedge clk) begin
    if (push) fmem[fwp] <= {in_last, in_data};
    if (accept && in_last) lenm[tag_now] <= LEN_W'(pos + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0; lkd <= 1'b0; tlm <= 1'b0; hd_pend <= 1'b0;
      pos <= '0; cur_tag <= '0; wp <= '0; rp <= '0; occ <= '0;
      alloc <= '0; done <= '0; closed <= '0; tailf <= '0; hif <= '0;
      fwp <= '0; frp <= '0; fcnt <= '0;
      lk_valid <= 1'b0; lk_data <= '0; lk_last <= 1'b0; lk_tag <= '0;
      tl_valid <= 1'b0; tl_data <= '0; tl_last <= 1'b0; tl_tag <= '0;
      ret_err <= 1'b0;
      rel_valid <= 1'b0; rel_tag <= '0; rel_len <= '0; rel_tail <= 1'b0; rel_hi <= 1'b0;
    end else begin
      lk_valid <= 1'b0;
      tl_valid <= 1'b0;

      if (start) begin
        alloc[wp]  <= 1'b1;
        done[wp]   <= 1'b0;
        closed[wp] <= 1'b0;
        hif[wp]    <= (in_data == ctrl_class);
        cur_tag    <= wp;
        wp         <= wp + 1'b1;
      end

      if (accept) begin
        pos    <= in_last ? '0 : pos + 1'b1;
        in_pkt <= !in_last;
        if (in_last) tailf[tag_now] <= (pos >= LEN_W'(WHOLE_MAX));
        if (pos == LEN_W'(WHOLE_MAX)) begin
          tlm     <= 1'b1;
          hd_pend <= 1'b1;
        end
        if (push && in_last && pos < LEN_W'(WHOLE_MAX)) lkd <= 1'b1;
      end

      if (direct) begin
        lk_valid <= 1'b1;
        lk_data  <= in_data;
        lk_last  <= in_last;
        lk_tag   <= tag_now;
        if (in_last) closed[tag_now] <= 1'b1;
      end

      if (pop) begin
        frp <= (frp == FP_W'(HOLD - 1)) ? '0 : frp + 1'b1;
        if (lkd || hd_pend) begin
          lk_valid <= 1'b1;
          lk_data  <= f_out[DATA_W-1:0];
          lk_last  <= lkd ? f_out[DATA_W] : 1'b1;
          lk_tag   <= cur_tag;
          hd_pend  <= 1'b0;
          if (lkd && f_out[DATA_W]) begin
            lkd <= 1'b0;
            closed[cur_tag] <= 1'b1;
          end
        end else begin
          tl_valid <= 1'b1;
          tl_data  <= f_out[DATA_W-1:0];
          tl_last  <= f_out[DATA_W];
          tl_tag   <= cur_tag;
          if (f_out[DATA_W]) begin
            tlm <= 1'b0;
            closed[cur_tag] <= 1'b1;
          end
        end
      end

      if (push) fwp <= (fwp == FP_W'(HOLD - 1)) ? '0 : fwp + 1'b1;
      fcnt <= fcnt + FC_W'(push) - FC_W'(pop);

      if (ret_ok) done[ret_tag] <= 1'b1;
      ret_err <= ret_valid && !ret_ok;

      rel_valid <= elig;
      if (elig) begin
        rel_tag   <= rp;
        rel_len   <= lenm[rp];
        rel_tail  <= tailf[rp];
        rel_hi    <= hif[rp];
        alloc[rp] <= 1'b0;
        rp        <= rp + 1'b1;
      end
      occ <= occ + OC_W'(start) - OC_W'(elig);
    end
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OC_W'(DEPTH) && !in_pkt) |-> !in_ready); // R7
  AST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && $past(rel_valid)) |-> (rel_tag == TAG_W'($past(rel_tag) + 1'b1))); // R5
  AST_TAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_tail == (rel_len > LEN_W'(WHOLE_MAX)))); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> $past(ret_valid)); // R8
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && tl_valid)); // R3
endmodule

// File: tb/head_tail_splitter_bench.sv
module head_tail_splitter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, ret_valid = 1'b0;
  logic [7:0] in_data = '0, ctrl_class = 8'hC3;
  logic [3:0] ret_tag = '0;
  logic in_ready, lk_valid, lk_last, tl_valid, tl_last, ret_err, rel_valid, rel_tail, rel_hi;
  logic [7:0] lk_data, tl_data;
  logic [3:0] lk_tag, tl_tag, rel_tag;
  logic [13:0] rel_len;

  head_tail_splitter u_head_tail_splitter (.*);

  always #5 clk = ~clk;

  int chk = 0, errs = 0, seq = 0, rel_cnt = 0;
  bit finished = 0, acc_q = 0;
  bit outst [16];
  bit rdone [16];
  logic [12:0] exp_lk [$];
  logic [12:0] exp_tl [$];
  logic [19:0] exp_rel [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    chk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) acc_q <= in_valid && in_ready;

  always @(negedge clk) if (rst_n) begin
    if (lk_valid) begin
      if (exp_lk.size() == 0) check(0, "R1 R2", "unexpected lookup beat", {lk_tag, lk_last, lk_data}, 0);
      else check(exp_lk.pop_front() == {lk_tag, lk_last, lk_data}, "R1 R2 R4", "lookup beat",
                 {lk_tag, lk_last, lk_data}, exp_lk[0]);
    end
    if (tl_valid) begin
      if (exp_tl.size() == 0) check(0, "R3", "unexpected tail beat", {tl_tag, tl_last, tl_data}, 0);
      else check(exp_tl.pop_front() == {tl_tag, tl_last, tl_data}, "R3 R4", "tail beat",
                 {tl_tag, tl_last, tl_data}, exp_tl[0]);
    end
    if (rel_valid) begin
      rel_cnt++;
      check(rdone[rel_tag], "R10", "release before return", rel_tag, 1);
      if (exp_rel.size() == 0) check(0, "R5", "unexpected release", rel_tag, 0);
      else check(exp_rel.pop_front() == {rel_tag, rel_len, rel_tail, rel_hi}, "R5 R6", "release record",
                 {rel_tag, rel_len, rel_tail, rel_hi}, exp_rel[0]);
      outst[rel_tag] = 0;
      rdone[rel_tag] = 0;
    end
  end

  function automatic logic [7:0] pbyte(input int i, input int len, input logic [7:0] b0);
    return (i == 0) ? b0 : 8'((i * 7 + len) & 8'hFF);
  endfunction

  task automatic send_pkt(input int len, input bit hi);
    logic [7:0] b0 = hi ? ctrl_class : 8'h11;
    logic [3:0] tag = 4'(seq % 16);
    int hl = (len > 224) ? 192 : len;
    seq++;
    outst[tag] = 1;
    for (int i = 0; i < hl; i++) exp_lk.push_back({tag, (i == hl - 1), pbyte(i, len, b0)});
    for (int i = 192; i < len && len > 224; i++) exp_tl.push_back({tag, (i == len - 1), pbyte(i, len, b0)});
    exp_rel.push_back({tag, 14'(len), (len > 224), hi});
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = pbyte(i, len, b0); in_last = (i == len - 1);
      do @(negedge clk); while (!acc_q);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic ret_send(input logic [3:0] t);
    bit exp_err = !(outst[t] && !rdone[t]);
    if (!exp_err) rdone[t] = 1;
    ret_valid = 1; ret_tag = t;
    @(negedge clk);
    ret_valid = 0;
    check(ret_err == exp_err, "R8", "ret_err after return", ret_err, exp_err);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !lk_valid && !tl_valid && !rel_valid && !ret_err, "R9", "reset state",
          {in_ready, lk_valid, tl_valid, rel_valid, ret_err}, 5'b10000);

    // R1 R2 R3 R6: length boundaries, tags 0..7
    send_pkt(1, 0); send_pkt(64, 1); send_pkt(191, 0); send_pkt(192, 1);
    send_pkt(193, 0); send_pkt(224, 1); send_pkt(225, 0); send_pkt(300, 1);
    idle(60);
    check(exp_lk.size() == 0, "R1 R2", "lookup beats outstanding", exp_lk.size(), 0);
    check(exp_tl.size() == 0, "R3", "tail beats outstanding", exp_tl.size(), 0);
    check(rel_cnt == 0, "R5", "release without return", rel_cnt, 0);

    // R10: out-of-order returns wait for the oldest
    ret_send(4'd3); ret_send(4'd2); ret_send(4'd1);
    idle(3); #1;
    check(rel_cnt == 0, "R10", "younger returns held", rel_cnt, 0);
    @(negedge clk);
    ret_send(4'd0);
    @(negedge clk); #1;
    check(rel_cnt == 1, "R5", "release two cycles after return", rel_cnt, 1);
    idle(4); #1;
    check(rel_cnt == 4, "R10", "burst release in order", rel_cnt, 4);

    // R8: bad returns change nothing
    @(negedge clk);
    ret_send(4'd0); ret_send(4'd9);
    ret_send(4'd5); ret_send(4'd5);
    idle(5); #1;
    check(rel_cnt == 4, "R8", "no release after bad returns", rel_cnt, 4);
    @(negedge clk);
    ret_send(4'd4); ret_send(4'd6); ret_send(4'd7);
    idle(6); #1;
    check(rel_cnt == 8 && exp_rel.size() == 0, "R5", "all eight released", rel_cnt, 8);

    // R7: full tracker backpressure, R4 wrap
    @(negedge clk);
    for (int k = 0; k < 16; k++) send_pkt(8, k[0]);
    idle(3);
    in_valid = 1; in_data = 8'h11; in_last = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(in_ready == 0, "R7", "ready low with 16 outstanding", in_ready, 0);
    end
    in_valid = 0;
    ret_send(4'd8);
    idle(2); #1;
    check(in_ready == 1, "R7", "ready after release", in_ready, 1);
    @(negedge clk);
    send_pkt(250, 1);
    base = 9;
    for (int k = 0; k < 16; k++) ret_send(4'((base + k) % 16));
    idle(40); #1;
    check(exp_rel.size() == 0 && rel_cnt == 25, "R5", "release count after wrap", rel_cnt, 25);

    // back-to-back long and short, returned in reverse
    @(negedge clk);
    send_pkt(260, 0); send_pkt(230, 1); send_pkt(200, 0);
    idle(50);
    ret_send(4'd11); ret_send(4'd10); ret_send(4'd9);
    idle(10); #1;
    check(exp_lk.size() == 0 && exp_tl.size() == 0, "R3", "streams drained", exp_lk.size() + exp_tl.size(), 0);
    check(exp_rel.size() == 0 && rel_cnt == 28, "R5", "final release count", rel_cnt, 28);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, chk);
    $finish;
  end
endmodule